// File: doc/BRIEF.md
# Interleaved I/Q Word Splitter for a Dual DAC

This block takes one parallel bus on which in-phase (I) and quadrature (Q) sample words arrive in turn, and sorts them into two channel registers that drive a pair of DAC cores. Every word is captured on the rising edge of the transmit clock.

An I word is parked in a hold register and does not reach either output when it arrives. On the edge that captures the next word (its Q partner), both channel registers load in the same cycle. The I output takes the parked word and the Q output takes the new word, so the two analog channels always step together.

A frame marker forces a word to be treated as I, which re-aligns the pairing after a glitch. An active-high standby input parks both channels at mid-scale and restarts the pairing. A one-cycle strobe marks each new output pair. Words are offset binary: code 0 is negative full scale, code 2^(DATA_W-1) (512 at the default width) is mid-scale, and all ones is positive full scale.

Top module: `iq_dac_demux`

## Requirements
- R1: On a rising edge with `rst_n` low, both `dac_i` and `dac_q` become mid-scale (512 at default width), `update` becomes 0, and the next accepted word is treated as an I word.
- R2: An I word is one accepted when the pairing expects I, or one accepted with `frame` high. It is stored internally and leaves `dac_i`, `dac_q` and `update` unchanged, except that `update` drops to 0.
- R3: A Q word is any accepted word that is not an I word. On the edge that samples it, `dac_i` takes the most recently stored I word and `dac_q` takes the Q word, both in that same cycle.
- R4: `update` is 1 for exactly the one cycle after each edge that loads a pair, and 0 at all other times. Back-to-back pairs give the pattern 0,1,0,1.
- R5: `frame` = 1 makes the sampled word an I word even when a Q word was expected. The earlier unpaired I word is discarded and never reaches `dac_i`.
- R6: On an edge with `standby` = 1, both outputs become mid-scale and `update` becomes 0. `din` and `frame` are ignored, and the first word accepted after standby is an I word.
- R7: Codes pass without change from `din` to the outputs, including the extreme codes 0 and 1023 and mid-scale 512.
- R8: Outside reset and standby, the outputs stay stable in every cycle in which `update` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Active-high: park both channels at mid-scale and restart the pairing |
| frame | input | 1 | High marks the word on `din` as an I word |
| din | input | DATA_W | Interleaved I/Q word bus, offset binary |
| dac_i | output | DATA_W | I channel code to its DAC core |
| dac_q | output | DATA_W | Q channel code to its DAC core |
| update | output | 1 | One-cycle pulse after a new pair is loaded |

## Verification
Every result is registered once, so it is due in the cycle after the edge that samples the input that causes it. For an I word, the visible result is only that the outputs do not move. A pair's outputs and its `update` pulse appear after the edge that samples the Q word. Standby and reset take effect after the first edge on which they are sampled.

The bench drives inputs on the falling edge and advances its behavioural model by one sampled edge. It then compares `dac_i`, `dac_q` and `update` on the next falling edge, which covers the single register stage on every path.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

   // which half of a pair the next accepted word belongs to
   typedef enum logic {
      PH_EXPECT_I = 1'b0,
      PH_EXPECT_Q = 1'b1
   } iqd_phase_e;

   // offset-binary mid-scale code for a given word width
   function automatic int unsigned mid_code(input int unsigned width);
      return 32'd1 << (width - 1);
   endfunction

endpackage

// File: rtl/iqd_phase_track.sv
module iqd_phase_track
   import iqd_pkg::*;
#(
   parameter bit FRAME_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby,
   input  logic frame,
   output logic word_is_q
);

   iqd_phase_e phase_q;
   logic       frame_hit;

   generate
      if (FRAME_EN) begin : g_frame
         assign frame_hit = frame;
      end else begin : g_noframe
         logic unused_frame;
         assign unused_frame = frame;
         assign frame_hit    = 1'b0;
      end
   endgenerate

   assign word_is_q = (phase_q == PH_EXPECT_Q) && !frame_hit;

   always_ff @(posedge clk) begin
      if (!rst_n || standby) begin
         phase_q <= PH_EXPECT_I;
      end else if (word_is_q) begin
         phase_q <= PH_EXPECT_I;
      end else begin
         phase_q <= PH_EXPECT_Q;
      end
   end

endmodule

// File: rtl/iqd_hold_reg.sv
module iqd_hold_reg #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/iqd_chan_out.sv
module iqd_chan_out #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned N_CH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic              load,
   input  logic [DATA_W-1:0] d   [N_CH],
   output logic [DATA_W-1:0] q   [N_CH],
   output logic              strobe
);

   localparam logic [DATA_W-1:0] MID = DATA_W'(iqd_pkg::mid_code(DATA_W));

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n || park) begin
               q[ch] <= MID;
            end else if (load) begin
               q[ch] <= d[ch];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || park) begin
         strobe <= 1'b0;
      end else begin
         strobe <= load;
      end
   end

endmodule

// File: rtl/iq_dac_demux.sv
module iq_dac_demux #(
   parameter int unsigned DATA_W   = 10,
   parameter bit          FRAME_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              frame,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dac_i,
   output logic [DATA_W-1:0] dac_q,
   output logic              update
);

   localparam int unsigned N_CH = 2;

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("iq_dac_demux: DATA_W must be within 2..16");
      end
   endgenerate

   logic              word_is_q;
   logic [DATA_W-1:0] held_i;
   logic [DATA_W-1:0] pair_d [N_CH];
   logic [DATA_W-1:0] pair_q [N_CH];

   iqd_phase_track #(.FRAME_EN(FRAME_EN)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby   (standby),
      .frame     (frame),
      .word_is_q (word_is_q)
   );

   iqd_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (standby),
      .load  (!word_is_q),
      .d     (din),
      .q     (held_i)
   );

   assign pair_d[0] = held_i;
   assign pair_d[1] = din;

   iqd_chan_out #(.DATA_W(DATA_W), .N_CH(N_CH)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .park   (standby),
      .load   (word_is_q),
      .d      (pair_d),
      .q      (pair_q),
      .strobe (update)
   );

   assign dac_i = pair_q[0];
   assign dac_q = pair_q[1];

endmodule

// File: rtl/iqd_chk.sv
module iqd_chk #(
   parameter int unsigned DATA_W   = 10,
   parameter bit          FRAME_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic              frame,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dac_i,
   input logic [DATA_W-1:0] dac_q,
   input logic              update
);

   localparam logic [DATA_W-1:0] MID = DATA_W'(iqd_pkg::mid_code(DATA_W));

   // R1: the cycle after a reset edge shows mid-scale and no strobe
   a_r1_reset_mid: assert property (@(posedge clk)
      $past(!rst_n) |-> (dac_i == MID && dac_q == MID && !update));

   // R6: the cycle after a standby edge shows mid-scale and no strobe
   a_r6_standby_mid: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(standby)) |-> (dac_i == MID && dac_q == MID && !update));

   // R3: a strobe means dac_q carries the word sampled on the previous edge
   a_r3_q_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
      update |-> dac_q == $past(din));

   // R4: a strobe cannot follow two edges in a row
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> !update);

   // R5: a framed word never completes a pair
   a_r5_frame_is_i: assert property (@(posedge clk) disable iff (!rst_n)
      (FRAME_EN && $past(rst_n) && $past(frame) && !$past(standby)) |-> !update);

   // R8: outputs hold between strobes
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(standby) && !update) |-> ($stable(dac_i) && $stable(dac_q)));

endmodule

bind iq_dac_demux iqd_chk #(.DATA_W(DATA_W), .FRAME_EN(FRAME_EN)) u_chk (.*);

// File: tb/iq_dac_demux_tb.sv
module iq_dac_demux_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W   = 10;
   localparam int MID = 512;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         standby = 1'b0;
   logic         frame = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dac_i;
   logic [W-1:0] dac_q;
   logic         update;

   int n_run  = 0;
   int n_fail = 0;

   // behavioural reference state
   int  m_i = MID, m_q = MID, m_upd = 0;
   bit  m_want_q = 0;
   int  m_held = 0;
   int  pending[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   iq_dac_demux u_dut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .frame(frame),
      .din(din), .dac_i(dac_i), .dac_q(dac_q), .update(update)
   );

   // Drive one cycle of inputs (we sit on a falling edge), advance the model
   // across the next rising edge, then compare on the following falling edge.
   task automatic cyc(input bit r, input bit sb, input bit fr, input int d, input string req);
      rst_n = r; standby = sb; frame = fr; din = W'(d);
      if (!r || sb) begin
         m_i = MID; m_q = MID; m_upd = 0; m_want_q = 0;
         pending.delete();
      end else if (fr || !m_want_q) begin
         pending.delete();
         pending.push_back(d);
         m_want_q = 1; m_upd = 0;
      end else begin
         m_held = pending.pop_front();
         m_i = m_held; m_q = d; m_upd = 1; m_want_q = 0;
      end
      @(negedge clk);
      n_run++;
      if (int'(dac_i) != m_i || int'(dac_q) != m_q || int'(update) != m_upd) begin
         n_fail++;
         $display("FAIL %s: got i=%0d q=%0d upd=%0d, expected i=%0d q=%0d upd=%0d",
                  req, dac_i, dac_q, update, m_i, m_q, m_upd);
      end
   endtask

   task automatic pair(input int vi, input int vq, input string req);
      cyc(1, 0, 1, vi, "R2");
      cyc(1, 0, 0, vq, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      cyc(0, 0, 0, 77, "R1");
      cyc(0, 0, 1, 88, "R1");
      // R2 first word held, outputs unchanged; R3 pair lands together
      cyc(1, 0, 0, 100, "R2");
      cyc(1, 0, 0, 200, "R3");
      // R4 back-to-back pairs without frame: 0,1,0,1
      cyc(1, 0, 0, 300, "R4");
      cyc(1, 0, 0, 400, "R4");
      // R7 extreme and mid codes
      pair(0, 1023, "R7");
      pair(1023, 0, "R7");
      pair(512, 512, "R7");
      // R8 idle cycles after an I word: outputs stable
      cyc(1, 0, 1, 11, "R8");
      cyc(1, 0, 1, 12, "R8");
      cyc(1, 0, 1, 13, "R8");
      cyc(1, 0, 0, 14, "R3");
      // R5 frame re-aligns: 5 discarded, pair is (7,9)
      cyc(1, 0, 0, 5, "R5");
      cyc(1, 0, 1, 7, "R5");
      cyc(1, 0, 0, 9, "R5");
      // R6 standby mid-pair: bus ignored, next word is I
      cyc(1, 0, 0, 33, "R6");
      cyc(1, 1, 0, 999, "R6");
      cyc(1, 1, 1, 1000, "R6");
      cyc(1, 0, 0, 44, "R6");
      cyc(1, 0, 0, 55, "R6");
      // R4 with standby between pairs
      pair(60, 61, "R4");
      cyc(1, 1, 0, 3, "R6");
      pair(62, 63, "R4");
      // R1 reset mid-pair: held I forgotten
      cyc(1, 0, 0, 70, "R1");
      cyc(0, 0, 0, 71, "R1");
      cyc(1, 0, 0, 72, "R1");
      cyc(1, 0, 0, 73, "R3");
      // pattern sweep
      for (int k = 0; k < 40; k++) begin
         cyc(1, 0, 0, (k * 97 + 13) % 1024, "R3");
         cyc(1, 0, 0, (k * 211 + 401) % 1024, "R3");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule